// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block steps a small 16-bit processor through taking an interrupt and coming back from one. At every instruction boundary it looks at the pending-interrupt flag. When that flag is set, it spends one clock on each of three micro-steps. The first step turns off the interrupt enable. The second pushes the current program counter onto a downward-growing stack. The third loads the program counter from the vector register while strobing that register's output enable. A return request at a boundary runs two steps instead. The first pulses the interrupt-clear strobe, which empties the pending latch and the interrupt flag. The second pops the saved program counter.

The block also holds the processor's flags. The arithmetic flags and the interrupt flag sit in separate registers, and each has its own load strobe, so loading one never disturbs the other. A third strobe loads the whole flag word from the data bus, and the same word is always presented for pushing to the stack. The block never saves general-purpose registers. Software does that when it needs to.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, busy_o, ie_o and pend_o are 0, flags_o is all zeros, and sp_o equals SP_RESET.
- R2: A boundary_i pulse while idle, with rti_i low and the interrupt flag (flags_o[AF_W]) set, makes busy_o high for exactly three cycles. ie_o is low from the second of those cycles onward.
- R3: In the second entry cycle, mem_we_o is high, mem_addr_o equals sp_o minus one, and mem_wdata_o equals pc_i. After that cycle, sp_o has dropped by one, and the arithmetic wraps modulo 2^ADDR_W.
- R4: In the third entry cycle, vec_oe_o and pc_load_o are high and pc_new_o equals vec_i.
- R5: A boundary_i pulse while idle with rti_i high gives a two-cycle return. In the first cycle irq_clr_o is high, and afterwards pend_o and the interrupt flag are 0. In the second cycle mem_re_o and pc_load_o are high, mem_addr_o equals sp_o, pc_new_o equals mem_rdata_i, and sp_o then rises by one.
- R6: When rti_i and the interrupt flag are both present at the same boundary, the return sequence runs and no entry step occurs.
- R7: boundary_i and rti_i have no effect while busy_o is high.
- R8: ie_o is set by ie_set_i and cleared by ie_clr_i, and the clear wins. pend_o becomes 1 the cycle after irq_req_i is seen while ie_o is 1, and it holds until the return clear step.
- R9: iflag_ld_i copies pend_o into flags_o[AF_W] and leaves flags_o[AF_W-1:0] unchanged. alu_flags_ld_i loads flags_o[AF_W-1:0] from alu_flags_i and leaves flags_o[AF_W] unchanged.
- R10: flags_ld_i loads all of flags_o from flags_bus_i, taking priority over both partial loads. The return clear step takes priority over flags_ld_i for the interrupt flag.
- R11: A boundary_i pulse while idle, with rti_i low and the interrupt flag clear, leaves busy_o low and no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | End of an ordinary instruction |
| rti_i | input | 1 | Return-from-interrupt request, qualified by boundary_i |
| irq_req_i | input | 1 | Interrupt request from the sources (active high) |
| ie_set_i | input | 1 | Enable interrupts |
| ie_clr_i | input | 1 | Disable interrupts |
| alu_flags_ld_i | input | 1 | Load the arithmetic flags |
| alu_flags_i | input | AF_W | New arithmetic flags |
| iflag_ld_i | input | 1 | Copy the pending latch into the interrupt flag |
| flags_ld_i | input | 1 | Load the whole flag word from the bus |
| flags_bus_i | input | AF_W+1 | Flag word from the bus |
| pc_i | input | DATA_W | Current program counter |
| vec_i | input | DATA_W | Vector register value |
| mem_rdata_i | input | DATA_W | Stack read data, valid in the same cycle |
| busy_o | output | 1 | Entry or return in progress |
| ie_o | output | 1 | Interrupt enable |
| pend_o | output | 1 | Pending-interrupt latch |
| flags_o | output | AF_W+1 | Flag word {interrupt flag, arithmetic flags} |
| vec_oe_o | output | 1 | Vector register output enable |
| irq_clr_o | output | 1 | Interrupt-clear strobe |
| pc_load_o | output | 1 | Load the program counter from pc_new_o |
| pc_new_o | output | DATA_W | New program counter |
| mem_we_o | output | 1 | Stack write |
| mem_re_o | output | 1 | Stack read |
| mem_addr_o | output | ADDR_W | Stack address |
| mem_wdata_o | output | DATA_W | Stack write data |
| sp_o | output | ADDR_W | Stack pointer |

## Verification
The bench builds the block with its default parameters: DATA_W and ADDR_W of 16, four arithmetic flags, and SP_RESET of zero. With a zero reset pointer, the very first push lands at 0xFFFF, and the matching pop wraps the pointer back to zero. This exercises the modular stack arithmetic early in the run. A four-bit arithmetic field, together with a random bus word, checks that each partial load leaves every bit of the other part intact.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIS  = 3'd1,
        ST_PUSH = 3'd2,
        ST_VEC  = 3'd3,
        ST_CLR  = 3'd4,
        ST_POP  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic dis;
        logic push;
        logic vec;
        logic clr;
        logic pop;
    } step_t;

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  boundary_i,
    input  logic  rti_i,
    input  logic  iflag_i,
    output step_t step_o,
    output logic  busy_o
);

    typedef struct packed {
        seq_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_IDLE: begin
                if (boundary_i) begin
                    if (rti_i) begin
                        fsm_d.st = ST_CLR;
                    end else if (iflag_i) begin
                        fsm_d.st = ST_DIS;
                    end
                end
            end
            ST_DIS:  fsm_d.st = ST_PUSH;
            ST_PUSH: fsm_d.st = ST_VEC;
            ST_VEC:  fsm_d.st = ST_IDLE;
            ST_CLR:  fsm_d.st = ST_POP;
            ST_POP:  fsm_d.st = ST_IDLE;
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        step_o.dis  = (fsm_q.st == ST_DIS);
        step_o.push = (fsm_q.st == ST_PUSH);
        step_o.vec  = (fsm_q.st == ST_VEC);
        step_o.clr  = (fsm_q.st == ST_CLR);
        step_o.pop  = (fsm_q.st == ST_POP);
        busy_o      = (fsm_q.st != ST_IDLE);
    end

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
    parameter int unsigned          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]    SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] sp;
    } sp_t;

    sp_t sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (push_i) begin
            sp_d.sp = sp_q.sp - ONE;
        end else if (pop_i) begin
            sp_d.sp = sp_q.sp + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q.sp <= SP_RESET;
        end else begin
            sp_q <= sp_d;
        end
    end

    // predecrement on push, read-then-increment on pop
    assign addr_o = push_i ? (sp_q.sp - ONE) : sp_q.sp;
    assign sp_o   = sp_q.sp;

endmodule

// File: rtl/irq_seq_flags.sv
module irq_seq_flags #(
    parameter int unsigned AF_W = 4,
    localparam int unsigned FL_W = AF_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_set_i,
    input  logic            ie_clr_i,
    input  logic            dis_i,
    input  logic            clr_i,
    input  logic            irq_req_i,
    input  logic            alu_ld_i,
    input  logic [AF_W-1:0] alu_i,
    input  logic            iflag_ld_i,
    input  logic            bus_ld_i,
    input  logic [FL_W-1:0] bus_i,
    output logic            ie_o,
    output logic            pend_o,
    output logic            iflag_o,
    output logic [FL_W-1:0] flags_o
);

    typedef struct packed {
        logic            ie;
        logic            pend;
        logic            iflag;
        logic [AF_W-1:0] af;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;

        // enable: sequencer disable and software clear win over set
        if (dis_i || ie_clr_i) begin
            fl_d.ie = 1'b0;
        end else if (ie_set_i) begin
            fl_d.ie = 1'b1;
        end

        // pending latch: clear step wins over a new request
        if (clr_i) begin
            fl_d.pend = 1'b0;
        end else if (irq_req_i && fl_q.ie) begin
            fl_d.pend = 1'b1;
        end

        // interrupt flag in its own register
        if (clr_i) begin
            fl_d.iflag = 1'b0;
        end else if (bus_ld_i) begin
            fl_d.iflag = bus_i[AF_W];
        end else if (iflag_ld_i) begin
            fl_d.iflag = fl_q.pend;
        end

        // arithmetic flags
        if (bus_ld_i) begin
            fl_d.af = bus_i[AF_W-1:0];
        end else if (alu_ld_i) begin
            fl_d.af = alu_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign ie_o    = fl_q.ie;
    assign pend_o  = fl_q.pend;
    assign iflag_o = fl_q.iflag;
    assign flags_o = {fl_q.iflag, fl_q.af};

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int unsigned       DATA_W   = 16,
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       AF_W     = 4,
    parameter logic [ADDR_W-1:0] SP_RESET = '0,
    localparam int unsigned      FL_W     = AF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              rti_i,
    input  logic              irq_req_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              alu_flags_ld_i,
    input  logic [AF_W-1:0]   alu_flags_i,
    input  logic              iflag_ld_i,
    input  logic              flags_ld_i,
    input  logic [FL_W-1:0]   flags_bus_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] vec_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              ie_o,
    output logic              pend_o,
    output logic [FL_W-1:0]   flags_o,
    output logic              vec_oe_o,
    output logic              irq_clr_o,
    output logic              pc_load_o,
    output logic [DATA_W-1:0] pc_new_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [ADDR_W-1:0] sp_o
);

    step_t             step;
    logic              iflag;
    logic [ADDR_W-1:0] sp_addr;

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .rti_i      (rti_i),
        .iflag_i    (iflag),
        .step_o     (step),
        .busy_o     (busy_o)
    );

    irq_seq_sp #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (step.push),
        .pop_i  (step.pop),
        .sp_o   (sp_o),
        .addr_o (sp_addr)
    );

    irq_seq_flags #(
        .AF_W (AF_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ie_set_i   (ie_set_i),
        .ie_clr_i   (ie_clr_i),
        .dis_i      (step.dis),
        .clr_i      (step.clr),
        .irq_req_i  (irq_req_i),
        .alu_ld_i   (alu_flags_ld_i),
        .alu_i      (alu_flags_i),
        .iflag_ld_i (iflag_ld_i),
        .bus_ld_i   (flags_ld_i),
        .bus_i      (flags_bus_i),
        .ie_o       (ie_o),
        .pend_o     (pend_o),
        .iflag_o    (iflag),
        .flags_o    (flags_o)
    );

    always_comb begin
        vec_oe_o    = step.vec;
        irq_clr_o   = step.clr;
        mem_we_o    = step.push;
        mem_re_o    = step.pop;
        pc_load_o   = step.vec | step.pop;
        pc_new_o    = '0;
        if (step.vec) begin
            pc_new_o = vec_i;
        end else if (step.pop) begin
            pc_new_o = mem_rdata_i;
        end
        mem_addr_o  = (step.push || step.pop) ? sp_addr : '0;
        mem_wdata_o = step.push ? pc_i : '0;
    end

endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned AF_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              ie_o,
    input logic              pend_o,
    input logic [AF_W:0]     flags_o,
    input logic              vec_oe_o,
    input logic              irq_clr_o,
    input logic              pc_load_o,
    input logic [DATA_W-1:0] pc_new_o,
    input logic [DATA_W-1:0] vec_i,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic [ADDR_W-1:0] sp_o
);

    p_dis_before_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !ie_o);

    p_sp_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (sp_o == $past(sp_o) - ADDR_W'(1)));

    p_vec_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (vec_oe_o && pc_load_o));

    p_vec_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (pc_new_o == vec_i));

    p_pop_after_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> (mem_re_o && pc_load_o && !flags_o[AF_W]));

    p_sp_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> (sp_o == $past(sp_o) + ADDR_W'(1)));

    p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o, vec_oe_o, irq_clr_o}));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_we_o || mem_re_o || vec_oe_o || irq_clr_o || pc_load_o));

    p_pend_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(ie_o));

endmodule

bind irq_sequencer irq_sequencer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .AF_W   (AF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .ie_o      (ie_o),
    .pend_o    (pend_o),
    .flags_o   (flags_o),
    .vec_oe_o  (vec_oe_o),
    .irq_clr_o (irq_clr_o),
    .pc_load_o (pc_load_o),
    .pc_new_o  (pc_new_o),
    .vec_i     (vec_i),
    .mem_we_o  (mem_we_o),
    .mem_re_o  (mem_re_o),
    .sp_o      (sp_o)
);

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int AF = 4;

    localparam int S_IDLE = 0, S_DIS = 1, S_PUSH = 2, S_VEC = 3, S_CLR = 4, S_POP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 0, rti_i = 0, irq_req_i = 0, ie_set_i = 0, ie_clr_i = 0;
    logic alu_flags_ld_i = 0, iflag_ld_i = 0, flags_ld_i = 0;
    logic [AF-1:0] alu_flags_i = '0;
    logic [AF:0]   flags_bus_i = '0;
    logic [DW-1:0] pc_i = '0, vec_i = '0, mem_rdata_i = '0;
    logic busy_o, ie_o, pend_o, vec_oe_o, irq_clr_o, pc_load_o, mem_we_o, mem_re_o;
    logic [AF:0]   flags_o;
    logic [DW-1:0] pc_new_o, mem_wdata_o;
    logic [AW-1:0] mem_addr_o, sp_o;

    always #2.5 clk = ~clk;

    irq_sequencer uut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .rti_i(rti_i),
        .irq_req_i(irq_req_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .alu_flags_ld_i(alu_flags_ld_i), .alu_flags_i(alu_flags_i),
        .iflag_ld_i(iflag_ld_i), .flags_ld_i(flags_ld_i), .flags_bus_i(flags_bus_i),
        .pc_i(pc_i), .vec_i(vec_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .ie_o(ie_o), .pend_o(pend_o), .flags_o(flags_o),
        .vec_oe_o(vec_oe_o), .irq_clr_o(irq_clr_o), .pc_load_o(pc_load_o),
        .pc_new_o(pc_new_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .sp_o(sp_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference state, derived from the requirements
    int            m_st;
    logic          m_ie, m_pend, m_if;
    logic [AF-1:0] m_af;
    logic [AW-1:0] m_sp;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int next_st(int s, logic b, logic r, logic f);
        case (s)
            S_IDLE:  return b ? (r ? S_CLR : (f ? S_DIS : S_IDLE)) : S_IDLE;
            S_DIS:   return S_PUSH;
            S_PUSH:  return S_VEC;
            S_CLR:   return S_POP;
            default: return S_IDLE;
        endcase
    endfunction

    // drive one cycle at the falling edge, check, advance the reference
    task automatic cyc(logic b, logic r, logic irq, logic ies, logic iec,
                       logic al, logic [AF-1:0] av, logic ifl, logic fl, logic [AF:0] bv);
        boundary_i = b; rti_i = r; irq_req_i = irq; ie_set_i = ies; ie_clr_i = iec;
        alu_flags_ld_i = al; alu_flags_i = av; iflag_ld_i = ifl;
        flags_ld_i = fl; flags_bus_i = bv;
        pc_i = DW'($urandom); vec_i = DW'($urandom); mem_rdata_i = DW'($urandom);
        #1;
        chk("R2", 32'(busy_o), 32'(m_st != S_IDLE));
        chk("R8", 32'(ie_o), 32'(m_ie));
        chk("R8", 32'(pend_o), 32'(m_pend));
        chk("R10", 32'(flags_o), 32'({m_if, m_af}));
        chk("R3", 32'(sp_o), 32'(m_sp));
        chk("R3", 32'(mem_we_o), 32'(m_st == S_PUSH));
        chk("R4", 32'(vec_oe_o), 32'(m_st == S_VEC));
        chk("R4", 32'(pc_load_o), 32'(m_st == S_VEC || m_st == S_POP));
        chk("R5", 32'(irq_clr_o), 32'(m_st == S_CLR));
        chk("R5", 32'(mem_re_o), 32'(m_st == S_POP));
        if (m_st == S_PUSH) begin
            chk("R3", 32'(mem_addr_o), 32'(AW'(m_sp - AW'(1))));
            chk("R3", 32'(mem_wdata_o), 32'(pc_i));
        end
        if (m_st == S_VEC) chk("R4", 32'(pc_new_o), 32'(vec_i));
        if (m_st == S_POP) begin
            chk("R5", 32'(mem_addr_o), 32'(m_sp));
            chk("R5", 32'(pc_new_o), 32'(mem_rdata_i));
        end
        begin
            logic          n_ie, n_pend, n_if;
            logic [AF-1:0] n_af;
            logic [AW-1:0] n_sp;
            n_ie   = (m_st == S_DIS || iec) ? 1'b0 : (ies ? 1'b1 : m_ie);
            n_pend = (m_st == S_CLR) ? 1'b0 : ((irq && m_ie) ? 1'b1 : m_pend);
            n_if   = (m_st == S_CLR) ? 1'b0 : (fl ? bv[AF] : (ifl ? m_pend : m_if));
            n_af   = fl ? bv[AF-1:0] : (al ? av : m_af);
            n_sp   = (m_st == S_PUSH) ? AW'(m_sp - AW'(1)) :
                     (m_st == S_POP)  ? AW'(m_sp + AW'(1)) : m_sp;
            m_st   = next_st(m_st, b, r, m_if);
            m_ie = n_ie; m_pend = n_pend; m_if = n_if; m_af = n_af; m_sp = n_sp;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, '0, 0, 0, '0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_st = S_IDLE; m_ie = 0; m_pend = 0; m_if = 0; m_af = '0; m_sp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", 32'(busy_o), 0);
        chk("R1", 32'(ie_o), 0);
        chk("R1", 32'(pend_o), 0);
        chk("R1", 32'(flags_o), 0);
        chk("R1", 32'(sp_o), 0);
        @(negedge clk);

        cyc(0, 0, 0, 1, 0, 0, '0, 0, 0, '0);          // enable
        cyc(0, 0, 1, 0, 0, 0, '0, 0, 0, '0);          // request -> pending
        chk("R8", 32'(pend_o), 1);
        cyc(0, 0, 0, 0, 0, 1, 4'hA, 1, 0, '0);        // both partial loads
        chk("R9", 32'(flags_o), 32'(5'h1A));
        cyc(0, 0, 0, 0, 0, 1, 4'h5, 0, 0, '0);        // arithmetic only
        chk("R9", 32'(flags_o), 32'(5'h15));
        cyc(1, 0, 0, 0, 0, 0, '0, 0, 0, '0);          // boundary -> entry
        chk("R2", 32'(busy_o), 1);
        cyc(1, 1, 0, 0, 0, 0, '0, 0, 0, '0);          // ignored while busy
        chk("R2", 32'(ie_o), 0);
        cyc(1, 0, 0, 0, 0, 0, '0, 0, 0, '0);          // push step
        chk("R3", 32'(sp_o), 32'(16'hFFFF));
        idle();                                         // vector step
        chk("R7", 32'(busy_o), 0);
        chk("R7", 32'(irq_clr_o), 0);
        cyc(1, 1, 0, 0, 0, 0, '0, 0, 0, '0);          // rti with flag set
        chk("R6", 32'(irq_clr_o), 1);
        chk("R6", 32'(mem_we_o), 0);
        idle();
        idle();
        chk("R6", 32'(busy_o), 0);
        chk("R5", 32'(sp_o), 0);
        chk("R5", 32'(flags_o[AF]), 0);
        cyc(1, 0, 0, 0, 0, 0, '0, 0, 0, '0);          // flag clear
        chk("R11", 32'(busy_o), 0);
        chk("R11", 32'(pc_load_o), 0);
        cyc(0, 0, 0, 0, 0, 1, 4'h3, 1, 1, 5'h1C);     // bus beats partials
        chk("R10", 32'(flags_o), 32'(5'h1C));
        cyc(0, 0, 1, 1, 1, 0, '0, 0, 0, '0);          // clear beats set
        chk("R8", 32'(ie_o), 0);
        cyc(0, 0, 1, 0, 0, 0, '0, 0, 0, '0);
        chk("R8", 32'(pend_o), 0);

        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                ($urandom % 6) == 0, ($urandom % 10) == 0,
                ($urandom % 4) == 0, AF'($urandom), ($urandom % 3) == 0,
                ($urandom % 16) == 0, (AF+1)'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule